// File: doc/BRIEF.md
# Legacy Super I/O Configuration Unlock

This block is the configuration-access gate of an older style of Super I/O device, seen from plain ISA I/O read and write strobes. The device has no configuration port fixed by strapping. Software first writes a four-byte pre-key to the plug-and-play address port. The first two bytes name the device family. The last two pick one of three configuration base ports. Software must then write a 32-byte initiation key to that base port before the configuration registers open.

Once the block is unlocked, a write to the base port selects a register index, and a read of the data port returns the indexed register. The chip-ID and version registers are readable this way. A single exit command returns the block to the locked state. While the block is locked, the base and data ports are not claimed: a read returns 0xFF and the undriven-bus flag is raised.

The 32 key bytes come from an 8-bit shift register seeded with 0x6A rather than from a stored table.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the block is locked. A read at 0x3F0, 0x3F1, 0x3BD, 0x3BF, 0x370 or 0x371 has io_claim_o=0 and io_float_o=1, and io_rdata_o reads 0xFF.
- R2: The pre-key goes to I/O address 0x279, one write per byte. Its first two bytes must equal the family code (parameters, default 0x86 then 0x61). A different family code leaves the block locked.
- R3: Pre-key bytes three and four pick the base port: {0x55,0x55} picks 0x3F0, {0x55,0xAA} picks 0x3BD, {0xAA,0x55} picks 0x370. Only the picked port, and its data port, answer after unlock.
- R4: After the pre-key, exactly 32 writes to the picked base port must carry, in order: 6A B5 DA ED F6 FB 7D BE DF 6F 37 1B 0D 86 C3 61 B0 58 2C 16 8B 45 A2 D1 E8 74 3A 9D CE E7 73 39. The last correct byte unlocks the block.
- R5: A wrong byte in the pre-key or the key restarts the sequence at the first pre-key byte. A 0x86 written to 0x279 at that moment is taken as a valid first byte.
- R6: When unlocked, a write to the base port sets the index. A data-port read returns 0x86 at index 0x20, 0x61 at 0x21, the version (default 0x01) at 0x22, and 0x00 at any other index. A base-port read returns the current index.
- R7: The data port is base+1 for bases 0x3F0 and 0x370, and base+2 for base 0x3BD. For base 0x3BD, address 0x3BE is not claimed.
- R8: Writing 0x02 to the data port while the index is 0x02 locks the block. Any other value written there keeps it unlocked.
- R9: A read that the block does not claim always returns 0xFF with io_float_o=1. A claimed read has io_float_o=0.
- R10: Writes to addresses other than 0x279 and the picked base port do not change the progress of an unlock in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, 0xFF when the read is not claimed |
| io_claim_o | output | 1 | The block drives the read data |
| io_float_o | output | 1 | A read is in progress and the bus is left undriven |

## Verification
The assertions assume that each I/O write lasts exactly one clock with stable address and data. They also assume that a read and a write never share a cycle, and that the claim and read data are only meaningful while io_rd_i is high. The bench drives every strobe for a single cycle from the falling edge and never overlaps reads with writes. Its random phase picks base ports, corrupted key positions and register indices, but it always keeps to whole single-cycle bus transfers.

// File: rtl/sio_unlock_pkg.sv
`timescale 1ns/1ps
package sio_unlock_pkg;
  typedef enum logic [2:0] {
    ST_PRE0, ST_PRE1, ST_PRE2, ST_PRE3, ST_KEY, ST_CFG
  } unlock_st_e;

  typedef enum logic [1:0] {PSEL_3F0, PSEL_3BD, PSEL_370} psel_e;

  localparam logic [7:0] SEL_LO = 8'h55;
  localparam logic [7:0] SEL_HI = 8'hAA;

  function automatic logic [15:0] base_of(psel_e s);
    case (s)
      PSEL_3BD: base_of = 16'h03BD;
      PSEL_370: base_of = 16'h0370;
      default:  base_of = 16'h03F0;
    endcase
  endfunction

  // 0x3BD has its data port two above the base
  function automatic logic [15:0] data_of(psel_e s);
    data_of = base_of(s) + ((s == PSEL_3BD) ? 16'd2 : 16'd1);
  endfunction
endpackage

// File: rtl/sio_key_lfsr.sv
`timescale 1ns/1ps
module sio_key_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED = 8'h6A
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         step_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        val_q <= SEED;
    else if (restart_i) val_q <= SEED;
    else if (step_i)    val_q <= {val_q[0] ^ val_q[1], val_q[W-1:1]};
  end

  assign value_o = val_q;
endmodule

// File: rtl/sio_unlock_fsm.sv
`timescale 1ns/1ps
module sio_unlock_fsm
  import sio_unlock_pkg::*;
#(
  parameter logic [7:0]  FAMILY_HI = 8'h86,
  parameter logic [7:0]  FAMILY_LO = 8'h61,
  parameter logic [15:0] PNP_ADDR  = 16'h0279,
  parameter int unsigned KEY_LEN   = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic [7:0]  key_byte_i,
  input  logic        exit_i,
  output logic        key_restart_o,
  output logic        key_step_o,
  output logic        cfg_o,
  output logic [15:0] base_o,
  output logic [15:0] data_port_o
);
  localparam int unsigned CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  unlock_st_e st_q, st_d;
  psel_e      psel_q, psel_d;
  logic       b3_hi_q, b3_hi_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic pnp_wr, base_wr, key_ok;
  unlock_st_e restart_st;

  assign base_o      = base_of(psel_q);
  assign data_port_o = data_of(psel_q);
  assign pnp_wr      = wr_i && (addr_i == PNP_ADDR);
  assign base_wr     = wr_i && (addr_i == base_o);
  assign key_ok      = base_wr && (wdata_i == key_byte_i);
  assign restart_st  = (pnp_wr && wdata_i == FAMILY_HI) ? ST_PRE1 : ST_PRE0;

  always_comb begin
    st_d    = st_q;
    psel_d  = psel_q;
    b3_hi_d = b3_hi_q;
    cnt_d   = cnt_q;
    case (st_q)
      ST_PRE0: if (pnp_wr && wdata_i == FAMILY_HI) st_d = ST_PRE1;
      ST_PRE1: if (pnp_wr) st_d = (wdata_i == FAMILY_LO) ? ST_PRE2 : restart_st;
      ST_PRE2: if (pnp_wr) begin
        if (wdata_i == SEL_LO || wdata_i == SEL_HI) begin
          b3_hi_d = (wdata_i == SEL_HI);
          st_d    = ST_PRE3;
        end else st_d = restart_st;
      end
      ST_PRE3: if (pnp_wr) begin
        st_d  = ST_KEY;
        cnt_d = '0;
        if (!b3_hi_q && wdata_i == SEL_LO)      psel_d = PSEL_3F0;
        else if (!b3_hi_q && wdata_i == SEL_HI) psel_d = PSEL_3BD;
        else if (b3_hi_q && wdata_i == SEL_LO)  psel_d = PSEL_370;
        else st_d = restart_st;
      end
      ST_KEY: begin
        if (pnp_wr) st_d = restart_st;
        else if (base_wr) begin
          if (!key_ok) st_d = ST_PRE0;
          else if (cnt_q == LAST) st_d = ST_CFG;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CFG: if (exit_i) st_d = ST_PRE0;
      default: st_d = ST_PRE0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PRE0;
      psel_q  <= PSEL_3F0;
      b3_hi_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      psel_q  <= psel_d;
      b3_hi_q <= b3_hi_d;
      cnt_q   <= cnt_d;
    end
  end

  assign key_restart_o = (st_q != ST_KEY);
  assign key_step_o    = (st_q == ST_KEY) && key_ok;
  assign cfg_o         = (st_q == ST_CFG);
endmodule

// File: rtl/sio_cfg_regs.sv
`timescale 1ns/1ps
module sio_cfg_regs #(
  parameter logic [7:0] CHIP_ID_HI = 8'h86,
  parameter logic [7:0] CHIP_ID_LO = 8'h61,
  parameter logic [7:0] CHIP_VER   = 8'h01,
  parameter logic [7:0] EXIT_IDX   = 8'h02,
  parameter logic [7:0] EXIT_VAL   = 8'h02
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic [15:0] base_i,
  input  logic [15:0] data_port_i,
  output logic [7:0]  rdata_o,
  output logic        claim_o,
  output logic        float_o,
  output logic        exit_o,
  output logic [7:0]  idx_o
);
  logic [7:0] idx_q, reg_val;
  logic base_hit, data_hit;

  assign base_hit = cfg_i && (addr_i == base_i);
  assign data_hit = cfg_i && (addr_i == data_port_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (!cfg_i)            idx_q <= '0;
    else if (wr_i && base_hit)  idx_q <= wdata_i;
  end

  always_comb begin
    case (idx_q)
      8'h20:   reg_val = CHIP_ID_HI;
      8'h21:   reg_val = CHIP_ID_LO;
      8'h22:   reg_val = CHIP_VER;
      default: reg_val = 8'h00;
    endcase
  end

  assign claim_o = rd_i && (base_hit || data_hit);
  assign float_o = rd_i && !claim_o;
  assign rdata_o = !claim_o ? 8'hFF : (base_hit ? idx_q : reg_val);
  assign exit_o  = wr_i && data_hit && (idx_q == EXIT_IDX) && (wdata_i == EXIT_VAL);
  assign idx_o   = idx_q;
endmodule

// File: rtl/sio_cfg_unlock.sv
`timescale 1ns/1ps
module sio_cfg_unlock #(
  parameter logic [7:0]  FAMILY_HI  = 8'h86,
  parameter logic [7:0]  FAMILY_LO  = 8'h61,
  parameter logic [15:0] PNP_ADDR   = 16'h0279,
  parameter int unsigned KEY_LEN    = 32,
  parameter logic [7:0]  KEY_SEED   = 8'h6A,
  parameter logic [7:0]  CHIP_ID_HI = 8'h86,
  parameter logic [7:0]  CHIP_ID_LO = 8'h61,
  parameter logic [7:0]  CHIP_VER   = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        io_claim_o,
  output logic        io_float_o
);
  logic [7:0]  key_byte, idx;
  logic        key_restart, key_step, cfg_mode, exit_cmd;
  logic [15:0] base, data_port;

  sio_key_lfsr #(.W(8), .SEED(KEY_SEED)) u_lfsr (
    .clk_i, .rst_ni,
    .restart_i (key_restart),
    .step_i    (key_step),
    .value_o   (key_byte)
  );

  sio_unlock_fsm #(
    .FAMILY_HI(FAMILY_HI), .FAMILY_LO(FAMILY_LO),
    .PNP_ADDR(PNP_ADDR), .KEY_LEN(KEY_LEN)
  ) u_fsm (
    .clk_i, .rst_ni,
    .wr_i          (io_wr_i),
    .addr_i        (io_addr_i),
    .wdata_i       (io_wdata_i),
    .key_byte_i    (key_byte),
    .exit_i        (exit_cmd),
    .key_restart_o (key_restart),
    .key_step_o    (key_step),
    .cfg_o         (cfg_mode),
    .base_o        (base),
    .data_port_o   (data_port)
  );

  sio_cfg_regs #(
    .CHIP_ID_HI(CHIP_ID_HI), .CHIP_ID_LO(CHIP_ID_LO), .CHIP_VER(CHIP_VER)
  ) u_regs (
    .clk_i, .rst_ni,
    .cfg_i       (cfg_mode),
    .wr_i        (io_wr_i),
    .rd_i        (io_rd_i),
    .addr_i      (io_addr_i),
    .wdata_i     (io_wdata_i),
    .base_i      (base),
    .data_port_i (data_port),
    .rdata_o     (io_rdata_o),
    .claim_o     (io_claim_o),
    .float_o     (io_float_o),
    .exit_o      (exit_cmd),
    .idx_o       (idx)
  );
endmodule

// File: rtl/sio_cfg_unlock_chk.sv
`timescale 1ns/1ps
module sio_cfg_unlock_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_wr_i,
  input logic        io_rd_i,
  input logic [15:0] io_addr_i,
  input logic [7:0]  io_wdata_i,
  input logic [7:0]  io_rdata_o,
  input logic        io_claim_o,
  input logic        io_float_o,
  input logic        cfg_mode,
  input logic [7:0]  idx,
  input logic [15:0] data_port
);
  AST_UNCLAIMED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_float_o |-> io_rdata_o == 8'hFF); // R9
  AST_CLAIM_NOT_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_claim_o && io_float_o)); // R9
  AST_CLAIM_NEEDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_claim_o |-> cfg_mode); // R1
  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i |-> (io_claim_o || io_float_o)); // R9
  AST_EXIT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode && io_wr_i && io_addr_i == data_port && idx == 8'h02 && io_wdata_i == 8'h02)
      |=> !cfg_mode); // R8
  AST_UNLOCK_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode) |-> $past(io_wr_i)); // R4
  AST_IDX_STABLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode && !io_wr_i) |=> (!cfg_mode || $stable(idx))); // R6
endmodule

bind sio_cfg_unlock sio_cfg_unlock_chk u_chk (
  .clk_i, .rst_ni, .io_wr_i, .io_rd_i, .io_addr_i, .io_wdata_i,
  .io_rdata_o, .io_claim_o, .io_float_o,
  .cfg_mode, .idx, .data_port
);

// File: tb/sio_cfg_unlock_bench.sv
`timescale 1ns/1ps
module sio_cfg_unlock_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic claim, flt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_cfg_unlock u_sio_cfg_unlock (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_rd_i(rd),
    .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .io_claim_o(claim), .io_float_o(flt)
  );

  localparam logic [7:0] KEY [32] = '{
    8'h6A,8'hB5,8'hDA,8'hED,8'hF6,8'hFB,8'h7D,8'hBE,8'hDF,8'h6F,8'h37,
    8'h1B,8'h0D,8'h86,8'hC3,8'h61,8'hB0,8'h58,8'h2C,8'h16,8'h8B,8'h45,
    8'hA2,8'hD1,8'hE8,8'h74,8'h3A,8'h9D,8'hCE,8'hE7,8'h73,8'h39};

  function automatic logic [15:0] base_for(int s);
    return (s == 0) ? 16'h03F0 : (s == 1) ? 16'h03BD : 16'h0370;
  endfunction
  function automatic logic [15:0] data_for(int s);
    return (s == 1) ? 16'h03BF : base_for(s) + 16'd1;
  endfunction
  function automatic logic [7:0] exp_reg(logic [7:0] i);
    return (i == 8'h20) ? 8'h86 : (i == 8'h21) ? 8'h61 : (i == 8'h22) ? 8'h01 : 8'h00;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d, output logic c, output logic f);
    @(negedge clk); rd = 1'b1; addr = a;
    #1; d = rdata; c = claim; f = flt;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic prekey(logic [7:0] lo, int s);
    io_write(16'h0279, 8'h86);
    io_write(16'h0279, lo);
    io_write(16'h0279, (s == 2) ? 8'hAA : 8'h55);
    io_write(16'h0279, (s == 1) ? 8'hAA : 8'h55);
  endtask

  task automatic send_key(int s, int bad);
    for (int i = 0; i < 32; i++)
      io_write(base_for(s), (i == bad) ? (KEY[i] ^ 8'h01) : KEY[i]);
  endtask

  // expects a locked port: unclaimed, floating, 0xFF
  task automatic expect_locked(logic [15:0] a, string req);
    logic [7:0] d; logic c, f;
    io_read(a, d, c, f);
    check(!c && f && d == 8'hFF, req, {7'd0, c, d}, 16'h00FF);
  endtask

  task automatic expect_reg(int s, logic [7:0] i, string req);
    logic [7:0] d; logic c, f;
    io_write(base_for(s), i);
    io_read(data_for(s), d, c, f);
    check(c && !f && d == exp_reg(i), req, {7'd0, c, d}, {8'h01, exp_reg(i)});
  endtask

  task automatic do_exit(int s);
    io_write(base_for(s), 8'h02);
    io_write(data_for(s), 8'h02);
  endtask

  initial begin
    logic [7:0] d; logic c, f;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (KEY[k]) if (k < 3) begin
      expect_locked(base_for(k), "R1 base after reset");
      expect_locked(data_for(k), "R1 data after reset");
    end

    // R3/R4/R6 unlock on 0x3F0
    prekey(8'h61, 0); send_key(0, -1);
    expect_reg(0, 8'h20, "R6 chip id hi");
    expect_reg(0, 8'h21, "R6 chip id lo");
    expect_reg(0, 8'h22, "R6 version");
    expect_reg(0, 8'h07, "R6 other index");
    io_read(16'h03F0, d, c, f);
    check(c && d == 8'h07, "R6 base readback", {7'd0, c, d}, 16'h0107);
    expect_locked(16'h0371, "R3 unpicked port");
    // R8 wrong exit value keeps unlocked
    io_write(16'h03F0, 8'h02); io_write(16'h03F1, 8'h01);
    expect_reg(0, 8'h21, "R8 non-exit value");
    do_exit(0);
    expect_locked(16'h03F1, "R8 after exit");
    expect_locked(16'h03F0, "R8 base after exit");

    // R7 0x3BD data at +2
    prekey(8'h61, 1); send_key(1, -1);
    expect_reg(1, 8'h20, "R7 3BD data port");
    expect_locked(16'h03BE, "R7 3BD base+1 unclaimed");
    do_exit(1);

    // R3/R7 0x370
    prekey(8'h61, 2); send_key(2, -1);
    expect_reg(2, 8'h22, "R7 370 data port");
    expect_locked(16'h03F1, "R3 370 picked, 3F1 unclaimed");
    do_exit(2);

    // R2 wrong family
    prekey(8'h80, 0); send_key(0, -1);
    expect_locked(16'h03F1, "R2 wrong family");

    // R5 bad key byte, then rest of key
    prekey(8'h61, 0); send_key(0, 17);
    expect_locked(16'h03F1, "R5 bad key byte");
    // R5 stray 0x86 restart accepted as first byte
    io_write(16'h0279, 8'h86);
    prekey(8'h61, 0); send_key(0, -1);
    expect_reg(0, 8'h20, "R5 0x86 restart");
    do_exit(0);
    // R5 bad third byte
    io_write(16'h0279, 8'h86); io_write(16'h0279, 8'h61); io_write(16'h0279, 8'h33);
    io_write(16'h0279, 8'h55); send_key(0, -1);
    expect_locked(16'h03F1, "R5 bad select byte");

    // R10 foreign writes interleaved
    prekey(8'h61, 0);
    for (int i = 0; i < 32; i++) begin
      io_write(16'h0080, 8'($urandom));
      io_write(16'h03F0, KEY[i]);
    end
    expect_reg(0, 8'h21, "R10 foreign writes ignored");
    do_exit(0);

    // random phase
    for (int n = 0; n < 40; n++) begin
      int s, bad;
      logic [7:0] i;
      s = int'($urandom % 3);
      bad = (($urandom % 4) == 0) ? int'($urandom % 32) : -1;
      i = (($urandom % 2) == 0) ? 8'h20 + 8'($urandom % 3) : 8'($urandom);
      if (i == 8'h02) i = 8'h03;
      prekey(8'h61, s); send_key(s, bad);
      if (bad < 0) begin
        expect_reg(s, i, "R4 random unlock");
        do_exit(s);
        expect_locked(data_for(s), "R8 random exit");
      end else begin
        expect_locked(data_for(s), "R5 random bad key");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule